// File: doc/BRIEF.md
# Four-Channel Coded-Rate PWM Generator

This block drives four independent pulse-width outputs from values held in a configuration register file. Each channel reads an 8-bit rate code, an 8-bit duty code, a polarity bit and an enable bit. The rate code sets the output frequency as a coarse step rate times a 6-bit multiplier. The duty code sets the active time in 1/256 steps of the period. A shared base tick enable paces every channel. A global mode input gates all outputs. Each channel also raises a one-cycle period-start strobe, which test logic uses to observe the period.

Each channel divides its period into 256 duty slots. A phase accumulator advances on each base tick by `(multiplier+1) << (2*step)`. Whenever the accumulator passes 4096, a slot tick is produced and the slot index moves on. When the accumulator increment is 4096, there is one slot per base tick.

Every channel has a two-state controller. In the `CH_OFF` state the output is held low and the counters are held at zero. In the `CH_RUN` state the output is generated. The **start** transition `CH_OFF -> CH_RUN` is taken when both the enable bit and the mode input are high. The **stop** transition `CH_RUN -> CH_OFF` is taken when either of them drops. Configuration changes while a channel is running take effect at once and do not restart its counters.

Top module: `pwm4_coded`

## Requirements
- R1: Rate code for channel i is `freq_codes[8i+7:8i]`. The step select is in bits 7:6 and the multiplier code in bits 5:0. With `tick_en` held high, the period is `256*4096 / ((code+1) << (2*step))` clock cycles whenever that division is exact. For example, step 3 with code 63 gives a 256-cycle period.
- R2: Duty code for channel i is `duty_codes[8i+7:8i]`. With normal polarity, the output is high for slots 0 through d of each period, which is (d+1)/256 of the period. Code 255 gives a constant high level, and no code gives zero high time.
- R3: Channel i is enabled by `en_reg[4+i]`. While that bit is clear, the output is low whatever the polarity bit says. Bits 3:0 of `en_reg` enable nothing.
- R4: Channel i is inverted by `pol_reg[2+i]`. When the bit is set, the high time becomes 256-(d+1) slots per period.
- R5: While `mode_normal` is low, every output is low and no period-start strobe occurs.
- R6: While `rst_n` is low, all outputs and strobes are low and all counters are cleared.
- R7: A change of duty code while a channel is running shows on the output in the same cycle. It does not move the timing of the next period-start strobe.
- R8: `period_start[i]` is a single-cycle pulse. It coincides with slot 0 of each period, so consecutive pulses are exactly one period apart.
- R9: On the start transition, the channel begins at slot 0. `period_start[i]` and the slot-0 output level appear in the cycle after the clock edge at which enable and mode were first both seen high.
- R10: Slots advance only on clock cycles where `tick_en` is high. Ticking every other cycle therefore doubles the period.
- R11: Each channel runs from its own rate and duty codes. Channels running at the same time with different codes each show their own period and high time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_normal | input | 1 | High when the device is in normal operating mode |
| tick_en | input | 1 | Base tick enable pacing the phase accumulators |
| freq_codes | input | 32 | Rate codes, 8 bits per channel, channel 0 in bits 7:0 |
| duty_codes | input | 32 | Duty codes, 8 bits per channel, channel 0 in bits 7:0 |
| pol_reg | input | 8 | Shared polarity register; bit 2+i inverts channel i |
| en_reg | input | 8 | Shared enable register; bit 4+i enables channel i |
| pwm_out | output | 4 | Channel output lines |
| period_start | output | 4 | Per-channel period-start strobe |

## Verification
The assertions check the cycle-level properties on every clock. These are: a disabled channel or the non-normal mode forces a low output, a running channel with full duty stays high, the strobe never lasts two cycles, a strobe on a steady channel always follows a base tick, and the outputs stay quiet during reset. The period lengths, the (d+1)/256 high-time ratio, the polarity inversion and the enable-bit positions can only be shown by the bench scenarios. The same holds for the restart at slot 0 on the start transition and for the in-place duty change that leaves strobe timing unchanged; the bench measures these over whole periods.

// File: rtl/pwm4_pkg.sv
package pwm4_pkg;
    typedef enum logic {
        CH_OFF = 1'b0,
        CH_RUN = 1'b1
    } ch_state_e;
endpackage

// File: rtl/pwm4_rate_accum.sv
module pwm4_rate_accum #(
    parameter int CNT_W  = 6,
    parameter int STEP_W = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hold,
    input  logic                    tick,
    input  logic [STEP_W+CNT_W-1:0] code,
    output logic                    slot_tick
);
    localparam int STEP_N    = 1 << STEP_W;
    localparam int SHIFT_MAX = 2 * (STEP_N - 1);
    localparam int MOD       = (1 << CNT_W) << SHIFT_MAX;
    localparam int ACC_W     = CNT_W + SHIFT_MAX + 1;

    logic [STEP_W-1:0] step;
    logic [ACC_W-1:0]  mult;
    logic [ACC_W-1:0]  inc;
    logic [ACC_W-1:0]  acc_q;
    logic [ACC_W-1:0]  sum;
    logic              wrap;

    assign step = code[STEP_W+CNT_W-1:CNT_W];

    always_comb begin
        mult      = ACC_W'(code[CNT_W-1:0]) + ACC_W'(1);
        inc       = mult << {step, 1'b0};
        sum       = acc_q + inc;
        wrap      = (sum >= ACC_W'(MOD));
        slot_tick = tick & wrap & ~hold;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
        end else if (hold) begin
            acc_q <= '0;
        end else if (tick) begin
            acc_q <= wrap ? (sum - ACC_W'(MOD)) : sum;
        end
    end
endmodule

// File: rtl/pwm4_channel.sv
module pwm4_channel
    import pwm4_pkg::*;
#(
    parameter int SLOT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_req,
    input  logic              slot_tick,
    input  logic [SLOT_W-1:0] duty,
    input  logic              pol,
    output logic              hold,
    output logic              pwm,
    output logic              start
);
    ch_state_e         state_q, state_d;
    logic [SLOT_W-1:0] slot_q;
    logic              start_q;

    // next-state logic: start and stop transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_OFF: if (run_req)  state_d = CH_RUN;
            CH_RUN: if (!run_req) state_d = CH_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_OFF;
        else        state_q <= state_d;
    end

    // slot counter and strobe register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q  <= '0;
            start_q <= 1'b0;
        end else begin
            start_q <= 1'b0;
            unique case (state_q)
                CH_OFF: begin
                    slot_q  <= '0;
                    start_q <= run_req;
                end
                CH_RUN: begin
                    if (!run_req) begin
                        slot_q <= '0;
                    end else if (slot_tick) begin
                        slot_q  <= slot_q + 1'b1;
                        start_q <= (slot_q == '1);
                    end
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        hold  = (state_q != CH_RUN);
        pwm   = (state_q == CH_RUN) & run_req & ((slot_q <= duty) ^ pol);
        start = start_q;
    end
endmodule

// File: rtl/pwm4_coded.sv
module pwm4_coded #(
    parameter  int CHANNELS = 4,
    parameter  int CNT_W    = 6,
    parameter  int STEP_W   = 2,
    parameter  int SLOT_W   = 8,
    localparam int FREQ_W   = STEP_W + CNT_W,
    localparam int POL_LSB  = 2,
    localparam int EN_LSB   = 4,
    localparam int REG_W    = EN_LSB + CHANNELS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       mode_normal,
    input  logic                       tick_en,
    input  logic [CHANNELS*FREQ_W-1:0] freq_codes,
    input  logic [CHANNELS*SLOT_W-1:0] duty_codes,
    input  logic [REG_W-1:0]           pol_reg,
    input  logic [REG_W-1:0]           en_reg,
    output logic [CHANNELS-1:0]        pwm_out,
    output logic [CHANNELS-1:0]        period_start
);
    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{pol_reg[POL_LSB-1:0],
                               pol_reg[REG_W-1:POL_LSB+CHANNELS],
                               en_reg[EN_LSB-1:0]};

    for (genvar i = 0; i < CHANNELS; i++) begin : g_ch
        logic run_req;
        logic hold;
        logic slot_tick;

        assign run_req = en_reg[EN_LSB+i] & mode_normal;

        pwm4_rate_accum #(
            .CNT_W  (CNT_W),
            .STEP_W (STEP_W)
        ) u_accum (
            .clk       (clk),
            .rst_n     (rst_n),
            .hold      (hold),
            .tick      (tick_en),
            .code      (freq_codes[i*FREQ_W +: FREQ_W]),
            .slot_tick (slot_tick)
        );

        pwm4_channel #(
            .SLOT_W (SLOT_W)
        ) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .run_req   (run_req),
            .slot_tick (slot_tick),
            .duty      (duty_codes[i*SLOT_W +: SLOT_W]),
            .pol       (pol_reg[POL_LSB+i]),
            .hold      (hold),
            .pwm       (pwm_out[i]),
            .start     (period_start[i])
        );
    end
endmodule

// File: rtl/pwm4_coded_chk.sv
module pwm4_coded_chk #(
    parameter  int CHANNELS = 4,
    parameter  int SLOT_W   = 8,
    localparam int EN_LSB   = 4,
    localparam int POL_LSB  = 2,
    localparam int REG_W    = EN_LSB + CHANNELS
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       mode_normal,
    input logic                       tick_en,
    input logic [CHANNELS*SLOT_W-1:0] duty_codes,
    input logic [REG_W-1:0]           pol_reg,
    input logic [REG_W-1:0]           en_reg,
    input logic [CHANNELS-1:0]        pwm_out,
    input logic [CHANNELS-1:0]        period_start
);
    // R5
    a_r5_mode_low: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_normal |-> (pwm_out == '0));

    // R6
    a_r6_reset_quiet: assert property (@(posedge clk)
        !rst_n |-> ((pwm_out == '0) && (period_start == '0)));

    for (genvar i = 0; i < CHANNELS; i++) begin : g_chk
        logic ok;
        assign ok = en_reg[EN_LSB+i] & mode_normal;

        // R3
        a_r3_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
            !en_reg[EN_LSB+i] |-> !pwm_out[i]);

        // R2
        a_r2_full_high: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(ok) && ok && !pol_reg[POL_LSB+i] &&
             (duty_codes[i*SLOT_W +: SLOT_W] == '1)) |-> pwm_out[i]);

        // R8
        a_r8_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
            period_start[i] |=> !period_start[i]);

        // R10
        a_r10_strobe_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n, 2) && $past(ok, 2) && $past(ok) && period_start[i])
                |-> $past(tick_en));
    end
endmodule

bind pwm4_coded pwm4_coded_chk #(
    .CHANNELS (CHANNELS),
    .SLOT_W   (SLOT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode_normal  (mode_normal),
    .tick_en      (tick_en),
    .duty_codes   (duty_codes),
    .pol_reg      (pol_reg),
    .en_reg       (en_reg),
    .pwm_out      (pwm_out),
    .period_start (period_start)
);

// File: tb/pwm4_coded_tb.sv
`timescale 1ns/1ps
module pwm4_coded_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_normal = 1'b1;
    logic        tick_en = 1'b1;
    logic        half_rate = 1'b0;
    logic [31:0] freq_codes = '0;
    logic [31:0] duty_codes = '0;
    logic [7:0]  pol_reg = '0;
    logic [7:0]  en_reg = '0;
    logic [3:0]  pwm_out;
    logic [3:0]  period_start;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    pwm4_coded u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_normal  (mode_normal),
        .tick_en      (tick_en),
        .freq_codes   (freq_codes),
        .duty_codes   (duty_codes),
        .pol_reg      (pol_reg),
        .en_reg       (en_reg),
        .pwm_out      (pwm_out),
        .period_start (period_start)
    );

    always @(negedge clk) tick_en <= half_rate ? ~tick_en : 1'b1;

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_chan(input int ch, input int step, input int code, input int duty);
        freq_codes[ch*8 +: 8] = {2'(step), 6'(code)};
        duty_codes[ch*8 +: 8] = 8'(duty);
    endtask

    // waits for a strobe, then counts samples and high samples up to the next one
    task automatic measure(input int ch, output int per, output int hi);
        int guard = 0;
        @(negedge clk);
        while (!period_start[ch] && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        per = 0;
        hi = 0;
        do begin
            per++;
            hi += int'(pwm_out[ch]);
            @(negedge clk);
        end while (!period_start[ch] && per < 20000);
    endtask

    task automatic quiet_window(input int n, output int highs, output int starts);
        highs = 0;
        starts = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            highs += $countones(pwm_out);
            starts += $countones(period_start);
        end
    endtask

    initial begin
        int per, hi, highs, starts, exp_p;
        int steps[6];
        int codes[6];
        steps = '{3, 3, 2, 3, 1, 2};
        codes = '{63, 31, 63, 15, 63, 31};

        // R6: reset state
        en_reg = 8'hF0;
        set_chan(0, 3, 63, 255);
        repeat (5) @(negedge clk);
        check(pwm_out == 4'b0, "R6 outputs low in reset", int'(pwm_out), 0);
        check(period_start == 4'b0, "R6 strobes low in reset", int'(period_start), 0);
        en_reg = 8'h00;
        @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R9: start transition begins at slot 0
        set_chan(0, 3, 63, 127);
        en_reg[4] = 1'b1;
        @(negedge clk);
        check(period_start[0] == 1'b1, "R9 strobe after start", int'(period_start[0]), 1);
        check(pwm_out[0] == 1'b1, "R9 slot0 level", int'(pwm_out[0]), 1);
        @(negedge clk);
        check(period_start[0] == 1'b0, "R8 strobe one cycle", int'(period_start[0]), 0);

        // R2 and R8: duty sweep on a 256-cycle period
        for (int d = 0; d < 256; d += 17) begin
            duty_codes[7:0] = 8'(d);
            measure(0, per, hi);
            check(per == 256, "R8 period spacing", per, 256);
            check(hi == d + 1, "R2 high time", hi, d + 1);
        end

        // R4: inverted polarity through pol_reg bit 2
        pol_reg[2] = 1'b1;
        foreach (codes[k]) begin
            int d;
            d = (k * 51) % 256;
            if (k == 5) d = 255;
            duty_codes[7:0] = 8'(d);
            measure(0, per, hi);
            check(hi == 255 - d, "R4 inverted high time", hi, 255 - d);
        end

        // R3: disabled channel stays low despite inversion
        duty_codes[7:0] = 8'd0;
        en_reg[4] = 1'b0;
        quiet_window(300, highs, starts);
        check(highs == 0, "R3 disabled low", highs, 0);
        en_reg = 8'h0F;
        pol_reg = 8'h3C;
        quiet_window(300, highs, starts);
        check(highs == 0, "R3 low bits enable nothing", highs, 0);
        check(starts == 0, "R3 no strobe when not enabled", starts, 0);
        pol_reg = 8'h00;

        // R5: mode gating
        en_reg = 8'hF0;
        mode_normal = 1'b0;
        quiet_window(300, highs, starts);
        check(highs == 0, "R5 mode low outputs", highs, 0);
        check(starts == 0, "R5 mode low strobes", starts, 0);
        mode_normal = 1'b1;
        en_reg = 8'h00;
        @(negedge clk);

        // R1: period versus rate code on channel 1
        en_reg[5] = 1'b1;
        foreach (steps[k]) begin
            set_chan(1, steps[k], codes[k], 127);
            exp_p = (256 * 4096) / ((codes[k] + 1) << (2 * steps[k]));
            measure(1, per, hi);
            measure(1, per, hi);
            check(per == exp_p, "R1 period", per, exp_p);
            check(hi == exp_p / 2, "R1 half duty", hi, exp_p / 2);
        end
        en_reg[5] = 1'b0;

        // R7: duty change takes effect at once, no restart
        set_chan(0, 3, 63, 200);
        en_reg[4] = 1'b1;
        measure(0, per, hi);
        // now at a strobe sample (slot 0)
        per = 1;
        repeat (100) begin
            @(negedge clk);
            per++;
        end
        check(pwm_out[0] == 1'b1, "R7 high before change", int'(pwm_out[0]), 1);
        duty_codes[7:0] = 8'd50;
        @(negedge clk);
        per++;
        check(pwm_out[0] == 1'b0, "R7 new duty immediate", int'(pwm_out[0]), 0);
        while (!period_start[0] && per < 2000) begin
            @(negedge clk);
            per++;
        end
        check(per - 1 == 256, "R7 strobe timing kept", per - 1, 256);

        // R10: tick every other cycle doubles the period
        duty_codes[7:0] = 8'd127;
        half_rate = 1'b1;
        measure(0, per, hi);
        measure(0, per, hi);
        check(per == 512, "R10 half-rate period", per, 512);
        check(hi == 256, "R10 half-rate high", hi, 256);
        half_rate = 1'b0;
        en_reg[4] = 1'b0;

        // R11: two channels with their own codes at once
        set_chan(2, 3, 31, 63);
        set_chan(3, 2, 63, 191);
        en_reg[6] = 1'b1;
        en_reg[7] = 1'b1;
        measure(2, per, hi);
        check(per == 512, "R11 ch2 period", per, 512);
        check(hi == 128, "R11 ch2 high", hi, 128);
        measure(3, per, hi);
        check(per == 1024, "R11 ch3 period", per, 1024);
        check(hi == 768, "R11 ch3 high", hi, 768);

        summary();
        $finish;
    end
endmodule